// File: doc/BRIEF.md
# Multi-cycle accumulator processor core

A small stored-program processor that keeps its instructions and its data in one shared memory, reached through a single synchronous port. Each 8-bit instruction word carries an opcode and a direct address. The core steps through fetch, decode and execute one register transfer at a time, using five architected registers: program counter, memory address register, memory data register, current instruction register and accumulator. The memory address register drives the memory address at all times.

A system loads the start address through a dedicated load input while the halt input is high. It then releases halt, and the core runs from that address. A value is taken from the input port only when the environment marks it valid. Each output instruction presents the accumulator with a one-cycle strobe. A finished program normally ends on a jump to its own address. The environment can stop the core at any time with halt, or restart it elsewhere with a new start-address load.

Top module: `acc_cpu`

## Requirements
- R1: After reset the program counter and accumulator are zero, the divide error flag is low, the core is idle, and no memory write, output strobe or input acknowledge is asserted.
- R2: A start-address load sets the program counter to `start_addr`, clears the divide error flag and puts the core in idle. High `halt` forces idle and holds it, with program counter and accumulator unchanged and no port activity. From idle the core starts a fetch at the current program counter on the first cycle that `halt` is low.
- R3: Bits 7:5 of an instruction are the opcode and bits 4:0 the direct address. Every fetch advances the program counter by one, wrapping from 31 to 0. The memory returns read data one cycle after the address.
- R4: Opcode 001 adds the memory operand to the accumulator, 010 subtracts it, and 110 loads it. Results wrap modulo 256.
- R5: Opcode 101 writes the accumulator to the addressed word. No other instruction writes memory.
- R6: Opcode 000 replaces the accumulator with the unsigned integer quotient of accumulator divided by the operand. A zero operand leaves the accumulator unchanged and sets a sticky `div_err` that only a start-address load or reset clears.
- R7: Opcode 011 waits in execute until `in_valid` is high, then loads `in_data` into the accumulator and raises `in_ack` for that one cycle only.
- R8: Opcode 100 presents the accumulator on `out_data` with `out_strobe` high for exactly one cycle.
- R9: Opcode 111 sets the program counter to the address field, without any data access, and fetches from there next.
- R10: The program counter changes only by a fetch increment, a jump, or a start-address load.
- R11: Measured from the start of one instruction to the start of the next, a jump takes 6 cycles, store, output and an input found valid take 7, add, subtract, load and divide by zero take 9, and a divide by a nonzero operand takes 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_load | input | 1 | Load `start_addr` into the program counter and go idle |
| start_addr | input | 5 | Address of the first instruction |
| halt | input | 1 | Force and hold the idle state |
| mem_addr | output | 5 | Shared memory address (memory address register) |
| mem_wdata | output | 8 | Memory write data (accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| in_data | input | 8 | Input port value |
| in_valid | input | 1 | Input value available |
| in_ack | output | 1 | Input value consumed this cycle |
| out_data | output | 8 | Output port value |
| out_strobe | output | 1 | One-cycle output strobe |
| acc | output | 8 | Accumulator |
| pc | output | 5 | Program counter |
| div_err | output | 1 | Sticky divide-by-zero flag |
| core_idle | output | 1 | Core is in its idle state |

## Verification
The assertions watch, on every cycle, the rules that tie control to state. They cover the legal ways the program counter may move, that only a store writes memory and only at the decoded address, that the output strobe and input acknowledge behave correctly, that halt and start-address loads force idle, and that the divide error flag is set and cleared correctly. The arithmetic results, the quotient, the order and values of the output stream, the memory image after a run, and the cycle cost of each instruction class only show up in the bench's scenarios. Those scenarios compare whole runs of directed and random programs against an instruction-level model.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              halt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ack,
  output logic [DATA_W-1:0] out_data,
  output logic              out_strobe,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic              div_err,
  output logic              core_idle
);
  localparam int OP_W  = DATA_W - ADDR_W;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [OP_W-1:0] OP_DIV = OP_W'(0);
  localparam logic [OP_W-1:0] OP_ADD = OP_W'(1);
  localparam logic [OP_W-1:0] OP_SUB = OP_W'(2);
  localparam logic [OP_W-1:0] OP_IN  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_OUT = OP_W'(4);
  localparam logic [OP_W-1:0] OP_STO = OP_W'(5);
  localparam logic [OP_W-1:0] OP_LD  = OP_W'(6);
  localparam logic [OP_W-1:0] OP_JMP = OP_W'(7);

  typedef enum logic [3:0] {
    S_IDLE, S_PC2MAR, S_INCPC, S_FREAD, S_FCAP, S_LDCIR,
    S_SPLIT, S_OREAD, S_OCAP, S_EXEC, S_DIV
  } state_t;

  state_t            state;
  logic [ADDR_W-1:0] pc_q, mar;
  logic [DATA_W-1:0] mdr, cir, acc_q, quo_q, rem_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;

  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] fld;
  logic              go, in_exec, needs_operand;
  logic [DATA_W:0]   rem_sh;
  logic              take;
  logic [DATA_W-1:0] rem_nx, quo_nx;

  assign op            = cir[DATA_W-1:ADDR_W];
  assign fld           = cir[ADDR_W-1:0];
  assign go            = !start_load && !halt;
  assign in_exec       = go && (state == S_EXEC);
  assign needs_operand = (op == OP_DIV) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_LD);

  assign rem_sh = {rem_q, quo_q[DATA_W-1]};
  assign take   = rem_sh >= {1'b0, mdr};
  assign rem_nx = take ? DATA_W'(rem_sh - {1'b0, mdr}) : rem_sh[DATA_W-1:0];
  assign quo_nx = {quo_q[DATA_W-2:0], take};

  assign mem_addr   = mar;
  assign mem_wdata  = acc_q;
  assign mem_we     = in_exec && (op == OP_STO);
  assign in_ack     = in_exec && (op == OP_IN) && in_valid;
  assign out_strobe = in_exec && (op == OP_OUT);
  assign out_data   = acc_q;
  assign acc        = acc_q;
  assign pc         = pc_q;
  assign div_err    = err_q;
  assign core_idle  = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc_q  <= '0;
      mar   <= '0;
      mdr   <= '0;
      cir   <= '0;
      acc_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (start_load) begin
      state <= S_IDLE;
      pc_q  <= start_addr;
      err_q <= 1'b0;
    end else if (halt) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:   state <= S_PC2MAR;
        S_PC2MAR: begin
          mar   <= pc_q;
          state <= S_INCPC;
        end
        S_INCPC:  begin
          pc_q  <= pc_q + ADDR_W'(1);
          state <= S_FREAD;
        end
        S_FREAD:  state <= S_FCAP;
        S_FCAP:   begin
          mdr   <= mem_rdata;
          state <= S_LDCIR;
        end
        S_LDCIR:  begin
          cir   <= mdr;
          state <= S_SPLIT;
        end
        S_SPLIT:  begin
          mar <= fld;
          if (op == OP_JMP) begin
            pc_q  <= fld;
            state <= S_PC2MAR;
          end else if (needs_operand) begin
            state <= S_OREAD;
          end else begin
            state <= S_EXEC;
          end
        end
        S_OREAD:  state <= S_OCAP;
        S_OCAP:   begin
          mdr   <= mem_rdata;
          state <= S_EXEC;
        end
        S_EXEC:   begin
          state <= S_PC2MAR;
          case (op)
            OP_ADD: acc_q <= acc_q + mdr;
            OP_SUB: acc_q <= acc_q - mdr;
            OP_LD:  acc_q <= mdr;
            OP_IN:  begin
              if (in_valid) acc_q <= in_data;
              else          state <= S_EXEC;
            end
            OP_DIV: begin
              if (mdr == '0) begin
                err_q <= 1'b1;
              end else begin
                rem_q <= '0;
                quo_q <= acc_q;
                cnt_q <= '0;
                state <= S_DIV;
              end
            end
            default: ;
          endcase
        end
        S_DIV:    begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            acc_q <= quo_nx;
            state <= S_PC2MAR;
          end
        end
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_load,
  input logic [ADDR_W-1:0] start_addr,
  input logic              halt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              in_valid,
  input logic              in_ack,
  input logic              out_strobe,
  input logic [DATA_W-1:0] acc,
  input logic [ADDR_W-1:0] pc,
  input logic              div_err,
  input logic              core_idle,
  input logic [DATA_W-1:0] cir
);
  assert_load_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_load |=> core_idle && (pc == $past(start_addr)));

  assert_halt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> core_idle);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_idle |-> !mem_we && !out_strobe && !in_ack);

  assert_store_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cir[DATA_W-1:ADDR_W] == 3'b101) && (mem_addr == cir[ADDR_W-1:0]));

  assert_div_zero_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_err) |-> acc == $past(acc));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_err) |-> $past(start_load));

  assert_ack_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> in_valid);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);

  assert_pc_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == ($past(pc) + ADDR_W'(1))) ||
                          (pc == $past(cir[ADDR_W-1:0])) || $past(start_load));
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_addr(start_addr),
  .halt(halt), .mem_we(mem_we), .mem_addr(mem_addr), .in_valid(in_valid),
  .in_ack(in_ack), .out_strobe(out_strobe), .acc(acc), .pc(pc),
  .div_err(div_err), .core_idle(core_idle), .cir(cir)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
  localparam int DW = 8;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_load = 1'b0;
  logic halt = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, in_data, out_data, acc;
  logic mem_we, in_valid, in_ack, out_strobe, div_err, core_idle;
  logic [AW-1:0] pc;

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [32];
  logic [DW-1:0] rm [32];
  logic [DW-1:0] inq [512];
  int in_idx = 0;
  logic in_en = 1'b1;
  logic [DW-1:0] outs [2048];
  int out_t [2048];
  int n_out = 0, cyc = 0;
  int in_base = 0, out_base = 0;

  logic [DW-1:0] e_acc;
  logic [DW-1:0] e_out [64];
  bit e_err;
  int e_nout, e_nin, e_pc;

  always #10 clk = ~clk;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_addr(start_addr),
    .halt(halt), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .in_data(in_data), .in_valid(in_valid), .in_ack(in_ack),
    .out_data(out_data), .out_strobe(out_strobe), .acc(acc), .pc(pc),
    .div_err(div_err), .core_idle(core_idle)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (in_ack) in_idx <= (in_idx + 1) % 512;
    in_valid <= in_en && ($urandom % 3 != 0);
  end
  assign in_data = inq[in_idx];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (out_strobe && n_out < 2048) begin
      outs[n_out] = out_data;
      out_t[n_out] = cyc;
      n_out = n_out + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  function automatic logic [7:0] ins(input int op, input int a);
    return {op[2:0], a[4:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) begin
      mem[i] = '0;
      rm[i] = '0;
    end
  endtask

  task automatic put(input int a, input logic [7:0] v);
    mem[a] = v;
    rm[a] = v;
  endtask

  // Instruction-level model built from the opcode table of the requirements
  task automatic model(input int start);
    int p = start;
    bit done = 0;
    e_err = 0;
    e_nout = 0;
    e_nin = 0;
    for (int s = 0; s < 400 && !done; s++) begin
      logic [7:0] w = rm[p];
      int f = int'(w[4:0]);
      int np = (p + 1) % 32;
      case (w[7:5])
        3'd0: if (rm[f] == 0) e_err = 1; else e_acc = e_acc / rm[f];
        3'd1: e_acc = e_acc + rm[f];
        3'd2: e_acc = e_acc - rm[f];
        3'd3: begin e_acc = inq[(in_base + e_nin) % 512]; e_nin++; end
        3'd4: begin if (e_nout < 64) e_out[e_nout] = e_acc; e_nout++; end
        3'd5: rm[f] = e_acc;
        3'd6: e_acc = rm[f];
        default: if (f == p) done = 1; else np = f;
      endcase
      if (!done) p = np;
    end
    e_pc = p;
  endtask

  task automatic launch(input int a);
    halt = 1'b1;
    @(negedge clk);
    in_base = in_idx;
    out_base = n_out;
    e_acc = acc;
    start_addr = AW'(a);
    start_load = 1'b1;
    @(negedge clk);
    start_load = 1'b0;
    halt = 1'b0;
  endtask

  task automatic stop();
    halt = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify();
    chk(acc == e_acc, "R4 accumulator after run", acc, e_acc);
    chk(div_err == e_err, "R6 div_err after run", div_err, e_err);
    chk(pc == AW'(e_pc) || pc == AW'(e_pc + 1), "R9 R10 pc parked at final jump", pc, e_pc);
    chk(in_idx - in_base == e_nin, "R7 inputs consumed", in_idx - in_base, e_nin);
    chk(n_out - out_base == e_nout, "R8 output count", n_out - out_base, e_nout);
    for (int k = 0; k < e_nout && k < 64; k++)
      chk(outs[out_base + k] == e_out[k], "R8 output value", outs[out_base + k], e_out[k]);
    for (int i = 0; i < 32; i++)
      chk(mem[i] == rm[i], "R5 memory word", mem[i], rm[i]);
  endtask

  task automatic run_prog(input int a, input int cycles);
    launch(a);
    model(a);
    repeat (cycles) @(negedge clk);
    stop();
    verify();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    int hp, ha, hn;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 512; i++) inq[i] = DW'($urandom);
    clear_mem();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pc == 0, "R1 pc after reset", pc, 0);
    chk(acc == 0, "R1 acc after reset", acc, 0);
    chk(div_err == 0, "R1 div_err after reset", div_err, 0);
    chk(core_idle == 1, "R1 idle after reset", core_idle, 1);
    chk(!out_strobe && !mem_we && !in_ack, "R1 quiet ports after reset", 1, 0);

    // R4 R5: wrap on add and subtract, store of the result
    clear_mem();
    put(16, 200); put(17, 100); put(18, 50);
    put(0, ins(6, 16)); put(1, ins(1, 17)); put(2, ins(2, 18));
    put(3, ins(4, 0)); put(4, ins(5, 20)); put(5, ins(7, 5));
    run_prog(0, 120);
    chk(acc == 250, "R4 wrapped result", acc, 250);
    chk(mem[20] == 250, "R5 stored word", mem[20], 250);

    // R6 divide, divide by zero, clear on start load
    clear_mem();
    put(16, 200); put(17, 7); put(18, 0); put(19, 1);
    put(0, ins(6, 16)); put(1, ins(0, 17)); put(2, ins(4, 0));
    put(3, ins(0, 18)); put(4, ins(4, 0)); put(5, ins(7, 5));
    put(8, ins(6, 16)); put(9, ins(0, 19)); put(10, ins(7, 10));
    run_prog(0, 150);
    chk(acc == 28, "R6 quotient kept after zero divisor", acc, 28);
    chk(div_err == 1, "R6 zero divisor flag", div_err, 1);
    run_prog(8, 120);
    chk(div_err == 0, "R6 flag cleared by start load", div_err, 0);
    chk(acc == 200, "R6 divide by one", acc, 200);

    // R9 jump skips instructions
    clear_mem();
    put(16, 11); put(17, 99);
    put(0, ins(6, 16)); put(1, ins(7, 4)); put(2, ins(6, 17)); put(3, ins(4, 0));
    put(4, ins(4, 0)); put(5, ins(7, 5));
    run_prog(0, 100);
    chk(n_out - out_base == 1 && outs[out_base] == 11, "R9 jump target output", outs[out_base], 11);

    // R3 program counter wraps from 31 to 0
    clear_mem();
    put(20, 42);
    put(31, ins(6, 20)); put(0, ins(4, 0)); put(1, ins(7, 1));
    run_prog(31, 80);
    chk(outs[out_base] == 42, "R3 wrap to address 0", outs[out_base], 42);

    // R11 cycle cost per instruction class, from strobe spacing
    clear_mem();
    put(16, 9); put(17, 3); put(18, 0);
    put(0, ins(4, 0)); put(1, ins(4, 0)); put(2, ins(1, 16)); put(3, ins(4, 0));
    put(4, ins(0, 17)); put(5, ins(4, 0)); put(6, ins(7, 8)); put(7, ins(4, 0));
    put(8, ins(4, 0)); put(9, ins(0, 18)); put(10, ins(4, 0)); put(11, ins(7, 11));
    run_prog(0, 160);
    begin
      int gap [5] = '{7, 16, 24, 13, 16};
      for (int k = 0; k < 5; k++)
        chk(out_t[out_base + k + 1] - out_t[out_base + k] == gap[k], "R11 cycles between strobes",
            out_t[out_base + k + 1] - out_t[out_base + k], gap[k]);
    end

    // R7 input stall then acceptance
    clear_mem();
    put(0, ins(3, 0)); put(1, ins(4, 0)); put(2, ins(7, 2));
    in_en = 1'b0;
    launch(0);
    repeat (40) @(negedge clk);
    chk(n_out == out_base, "R7 no output while stalled", n_out - out_base, 0);
    chk(in_idx == in_base, "R7 no acknowledge without valid", in_idx - in_base, 0);
    chk(core_idle == 0, "R7 stalled core not idle", core_idle, 0);
    in_en = 1'b1;
    model(0);
    repeat (60) @(negedge clk);
    stop();
    verify();
    chk(outs[out_base] == inq[in_base], "R7 input value passed to output", outs[out_base], inq[in_base]);

    // R2 halt freezes, release resumes, start load mid-run restarts
    clear_mem();
    put(16, 1); put(17, 77);
    put(0, ins(1, 16)); put(1, ins(4, 0)); put(2, ins(7, 0));
    put(10, ins(6, 17)); put(11, ins(4, 0)); put(12, ins(7, 12));
    launch(0);
    repeat (100) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    chk(core_idle == 1, "R2 halt forces idle", core_idle, 1);
    hp = pc; ha = acc; hn = n_out;
    repeat (30) @(negedge clk);
    chk(pc == hp, "R2 pc held during halt", pc, hp);
    chk(acc == ha, "R2 acc held during halt", acc, ha);
    chk(n_out == hn, "R2 no output during halt", n_out, hn);
    halt = 1'b0;
    repeat (60) @(negedge clk);
    chk(n_out > hn, "R2 resumes after halt release", n_out - hn, 1);
    start_addr = AW'(10);
    start_load = 1'b1;
    @(negedge clk);
    start_load = 1'b0;
    chk(core_idle == 1, "R2 start load forces idle", core_idle, 1);
    chk(pc == 10, "R2 start load sets pc", pc, 10);
    repeat (60) @(negedge clk);
    chk(acc == 77, "R2 restart runs new code", acc, 77);
    chk(outs[n_out - 1] == 77, "R2 restart output", outs[n_out - 1], 77);
    stop();

    // Random straight-line programs against the model
    for (int r = 0; r < 12; r++) begin
      clear_mem();
      for (int i = 16; i < 32; i++) put(i, ($urandom % 5 == 0) ? 8'd0 : DW'($urandom));
      put(0, ins(6, 16 + $urandom % 16));
      for (int i = 1; i < 15; i++) put(i, ins($urandom % 7, 16 + $urandom % 16));
      put(15, ins(7, 15));
      run_prog(0, 900);
    end

    report();
    $finish;
  end
endmodule